// File: doc/BRIEF.md
# Idle-Strobe Power-Down and Input Gating Controller

This block sits beside a programmable logic array and its memories on a microcontroller bus. It watches the bus address strobe and, when automatic power-down is enabled, counts clocks during which the strobe rests at a programmable level. After a fixed run of such idle clocks it raises a power-down flag. Any movement of the strobe clears the run and drops the flag.

Two 8-bit power-management registers also control gating. One register holds the power-down enable, the strobe level selection, and two bits that cut the input clock off from the AND array and from the output macrocells. The other register cuts individual control inputs, the address strobe and the byte-enable input off from the AND array. A gated signal is held at logic 0. An active-low chip select drives the memory enable. It does not affect the gating paths.

Top module: `pwrIdleGate`

## Requirements
- R1: When the enable bit (bit 0 of register 0) is 0, the idle count stays at zero and `pwrDown` stays 0, whatever the strobe does.
- R2: A strobe that changes level clears the idle run. `pwrDown` is 0 from the clock edge at which the change is first sampled, so a strobe that toggles every cycle never raises `pwrDown`.
- R3: Counting happens only while the strobe is held at the level chosen by the polarity bit (bit 1 of register 0: 1 selects high, 0 selects low). A strobe held at the other level keeps the count at zero.
- R4: With the enable bit set, change the strobe to the selected level and then hold it there. `pwrDown` is 0 after the 15th rising edge that follows and 1 after the 16th, which is 15 counting clocks. The count saturates, and `pwrDown` stays 1 for as long as the strobe holds.
- R5: `memEnable` is 1 while `chipSelN` is 0 and is 0 while `chipSelN` is 1. The chip select has no effect on any gated output.
- R6: Bit 4 of register 0 forces `arrayClk` to 0, and bit 5 forces `cellClk` to 0. Otherwise each one follows `clk`.
- R7: Bits 2, 3, 4, 5 and 6 of register 2 force to 0 `ctlGated[0]`, `ctlGated[1]`, `ctlGated[2]`, `strobeGated` and `byteEnGated`, in that order. A clear bit passes its input through unchanged.
- R8: A synchronous reset clears both registers, the idle count and `pwrDown`, so after reset every input passes through ungated.
- R9: Clearing the enable bit while `pwrDown` is 1 drops `pwrDown` at the same clock edge that writes the register.
- R10: A write with `regWrEn` high updates register 0 when `regSel` is 0 and register 2 when `regSel` is 1, on the rising clock edge. The other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the input clock being gated |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects register 0, 1 selects register 2 |
| regWrData | input | 8 | Register write data |
| strobeIn | input | 1 | Bus address strobe |
| ctlIn | input | 3 | Control inputs to the AND array |
| byteEnIn | input | 1 | Data byte-enable input |
| chipSelN | input | 1 | Chip select, active low |
| arrayClk | output | 1 | Clock to the AND array |
| cellClk | output | 1 | Clock to the output macrocells |
| ctlGated | output | 3 | Gated control inputs |
| strobeGated | output | 1 | Gated address strobe |
| byteEnGated | output | 1 | Gated byte enable |
| memEnable | output | 1 | Memory enable |
| pwrDown | output | 1 | Power-down request |

## Verification
A wrong idle count shows up only as the timing of `pwrDown`. A count that is off by one moves the rise by one edge, so the bench samples on both sides of the 16th edge after the strobe settles. A missing clear is visible within one cycle of a strobe change, a disable write or a reset, because the flag stays high when it should drop. A register bit that is stuck or misplaced shows up at once as a gated output that takes the wrong value for a given input pattern.

// File: rtl/pwrIdlePkg.sv
package pwrIdlePkg;
  localparam int REG_W        = 8;
  localparam int AUTO_EN_BIT  = 0;
  localparam int POL_BIT      = 1;
  localparam int ARR_CLK_BIT  = 4;
  localparam int CELL_CLK_BIT = 5;
  localparam int GATE_LO_BIT  = 2;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } idleStrobes_t;
endpackage

// File: rtl/pwrIdleCtrl.sv
module pwrIdleCtrl
  import pwrIdlePkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         strobeIn,
  input  logic         autoEn,
  input  logic         strobePol,
  input  logic         cntAtMax,
  output idleStrobes_t strb
);
  logic strobePrev;
  logic edgeSeen;
  logic levelOk;

  always_ff @(posedge clk) begin
    if (rst) strobePrev <= 1'b0;
    else     strobePrev <= strobeIn;
  end

  always_comb begin
    edgeSeen      = strobeIn ^ strobePrev;
    levelOk       = (strobeIn == strobePol);
    strb.cntClear = !autoEn || edgeSeen || !levelOk;
    strb.cntInc   = !strb.cntClear && !cntAtMax;
  end
endmodule

// File: rtl/pwrIdleDatapath.sv
module pwrIdleDatapath
  import pwrIdlePkg::*;
#(
  parameter int THRESH = 15,
  parameter int CTL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  input  idleStrobes_t     strb,
  input  logic             strobeIn,
  input  logic [CTL_W-1:0] ctlIn,
  input  logic             byteEnIn,
  input  logic             chipSelN,
  output logic             autoEn,
  output logic             strobePol,
  output logic             cntAtMax,
  output logic             arrayClk,
  output logic             cellClk,
  output logic [CTL_W-1:0] ctlGated,
  output logic             strobeGated,
  output logic             byteEnGated,
  output logic             memEnable,
  output logic             pwrDown
);
  localparam int CNT_W      = $clog2(THRESH + 1);
  localparam int STROBE_BIT = GATE_LO_BIT + CTL_W;
  localparam int BE_BIT     = STROBE_BIT + 1;

  logic [REG_W-1:0] pmReg0;
  logic [REG_W-1:0] pmReg2;
  logic [CNT_W-1:0] idleCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pmReg0 <= '0;
      pmReg2 <= '0;
    end else if (regWrEn) begin
      if (regSel) pmReg2 <= regWrData;
      else        pmReg0 <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.cntClear) idleCnt <= '0;
    else if (strb.cntInc)     idleCnt <= idleCnt + 1'b1;
  end

  assign autoEn    = pmReg0[AUTO_EN_BIT];
  assign strobePol = pmReg0[POL_BIT];
  assign cntAtMax  = (idleCnt == CNT_W'(THRESH));
  assign pwrDown   = cntAtMax && autoEn;

  assign arrayClk  = clk & ~pmReg0[ARR_CLK_BIT];
  assign cellClk   = clk & ~pmReg0[CELL_CLK_BIT];
  assign memEnable = ~chipSelN;

  for (genvar i = 0; i < CTL_W; i++) begin : gCtlGate
    assign ctlGated[i] = ctlIn[i] & ~pmReg2[GATE_LO_BIT + i];
  end
  assign strobeGated = strobeIn & ~pmReg2[STROBE_BIT];
  assign byteEnGated = byteEnIn & ~pmReg2[BE_BIT];
endmodule

// File: rtl/pwrIdleGate.sv
module pwrIdleGate
  import pwrIdlePkg::*;
#(
  parameter int THRESH = 15,
  parameter int CTL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  input  logic             strobeIn,
  input  logic [CTL_W-1:0] ctlIn,
  input  logic             byteEnIn,
  input  logic             chipSelN,
  output logic             arrayClk,
  output logic             cellClk,
  output logic [CTL_W-1:0] ctlGated,
  output logic             strobeGated,
  output logic             byteEnGated,
  output logic             memEnable,
  output logic             pwrDown
);
  idleStrobes_t strb;
  logic autoEn;
  logic strobePol;
  logic cntAtMax;

  pwrIdleCtrl uCtrl (
    .clk(clk), .rst(rst), .strobeIn(strobeIn), .autoEn(autoEn),
    .strobePol(strobePol), .cntAtMax(cntAtMax), .strb(strb)
  );

  pwrIdleDatapath #(.THRESH(THRESH), .CTL_W(CTL_W)) uDp (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .strb(strb), .strobeIn(strobeIn), .ctlIn(ctlIn),
    .byteEnIn(byteEnIn), .chipSelN(chipSelN), .autoEn(autoEn),
    .strobePol(strobePol), .cntAtMax(cntAtMax), .arrayClk(arrayClk),
    .cellClk(cellClk), .ctlGated(ctlGated), .strobeGated(strobeGated),
    .byteEnGated(byteEnGated), .memEnable(memEnable), .pwrDown(pwrDown)
  );
endmodule

// File: rtl/pwrIdleGate_chk.sv
module pwrIdleGate_chk #(
  parameter int CTL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             strobeIn,
  input logic             chipSelN,
  input logic             memEnable,
  input logic             pwrDown,
  input logic             autoEn,
  input logic             strobePol,
  input logic [CTL_W-1:0] ctlIn,
  input logic [CTL_W-1:0] ctlGated
);
  AST_NO_PDN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !autoEn |-> !pwrDown); // R1

  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (strobeIn != $past(strobeIn)) |=> !pwrDown); // R2

  AST_RISE_AT_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $rose(pwrDown) |-> $past(strobeIn == strobePol)); // R3

  AST_MEM_OFF: assert property (@(posedge clk) disable iff (rst)
    chipSelN |-> !memEnable); // R5

  AST_GATE_ONLY_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (ctlGated & ~ctlIn) == '0); // R7
endmodule

bind pwrIdleGate pwrIdleGate_chk #(.CTL_W(CTL_W)) uChk (
  .clk(clk), .rst(rst), .strobeIn(strobeIn), .chipSelN(chipSelN),
  .memEnable(memEnable), .pwrDown(pwrDown), .autoEn(autoEn),
  .strobePol(strobePol), .ctlIn(ctlIn), .ctlGated(ctlGated)
);

// File: tb/pwrIdleGate_test.sv
module pwrIdleGate_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       regWrEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWrData = '0;
  logic       strobeIn = 1'b0;
  logic [2:0] ctlIn = '0;
  logic       byteEnIn = 1'b0;
  logic       chipSelN = 1'b1;
  logic       arrayClk, cellClk, strobeGated, byteEnGated, memEnable, pwrDown;
  logic [2:0] ctlGated;

  int  nChecks = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  pwrIdleGate uut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .strobeIn(strobeIn), .ctlIn(ctlIn),
    .byteEnIn(byteEnIn), .chipSelN(chipSelN), .arrayClk(arrayClk),
    .cellClk(cellClk), .ctlGated(ctlGated), .strobeGated(strobeGated),
    .byteEnGated(byteEnGated), .memEnable(memEnable), .pwrDown(pwrDown)
  );

  typedef struct packed {
    logic [7:0] r0;
    logic [7:0] r2;
    logic [2:0] ctl;
    logic       stb;
    logic       be;
    logic       csn;
    logic [2:0] eCtl;
    logic       eStb;
    logic       eBe;
    logic       eMem;
    logic       eArr;
    logic       eCell;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 8'h00, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    '{8'h10, 8'h00, 3'b111, 1'b1, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{8'h20, 8'h04, 3'b111, 1'b1, 1'b1, 1'b0, 3'b110, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{8'h30, 8'h08, 3'b011, 1'b0, 1'b1, 1'b1, 3'b001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h00, 8'h10, 3'b100, 1'b1, 1'b1, 1'b0, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    '{8'h00, 8'h20, 3'b101, 1'b1, 1'b1, 1'b0, 3'b101, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    '{8'h00, 8'h40, 3'b010, 1'b1, 1'b1, 1'b0, 3'b010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{8'h00, 8'h7C, 3'b111, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic checkClocks(input logic eArr, input logic eCell, input string req);
    @(posedge clk); #1;
    check(arrayClk == eArr, req, arrayClk, eArr);
    check(cellClk == eCell, req, cellClk, eCell);
    @(negedge clk); #1;
    check(arrayClk == 1'b0, req, arrayClk, 0);
  endtask

  // Strobe starts at the opposite level; arms with polarity, then moves it.
  task automatic runIdle(input logic pol, input string req);
    @(negedge clk); strobeIn = ~pol;
    writeReg(1'b0, {6'b0, pol, 1'b1});
    strobeIn = pol;
    repeat (15) @(negedge clk);
    #1 check(pwrDown == 1'b0, req, pwrDown, 0);
    @(negedge clk);
    #1 check(pwrDown == 1'b1, req, pwrDown, 1);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    ctlIn = 3'b101; byteEnIn = 1'b1; strobeIn = 1'b1; chipSelN = 1'b0;
    rst = 1'b0;
    #1;
    // R8: reset state passes everything through
    check(pwrDown == 1'b0, "R8", pwrDown, 0);
    check(ctlGated == 3'b101, "R8", ctlGated, 5);
    check(strobeGated == 1'b1 && byteEnGated == 1'b1, "R8",
          {strobeGated, byteEnGated}, 3);
    checkClocks(1'b1, 1'b1, "R8");

    // Table walk: R5, R6, R7, R10
    for (int i = 0; i < NVEC; i++) begin
      writeReg(1'b0, VECS[i].r0);
      writeReg(1'b1, VECS[i].r2);
      ctlIn = VECS[i].ctl; strobeIn = VECS[i].stb;
      byteEnIn = VECS[i].be; chipSelN = VECS[i].csn;
      #1;
      check(ctlGated == VECS[i].eCtl, "R7", ctlGated, VECS[i].eCtl);
      check(strobeGated == VECS[i].eStb, "R7", strobeGated, VECS[i].eStb);
      check(byteEnGated == VECS[i].eBe, "R7", byteEnGated, VECS[i].eBe);
      check(memEnable == VECS[i].eMem, "R5", memEnable, VECS[i].eMem);
      checkClocks(VECS[i].eArr, VECS[i].eCell, "R6");
    end

    // R10: writing register 2 leaves register 0 untouched
    writeReg(1'b0, 8'h10);
    writeReg(1'b1, 8'h00);
    checkClocks(1'b0, 1'b1, "R10");
    writeReg(1'b0, 8'h00);

    // R1: disabled, steady strobe never powers down
    @(negedge clk); strobeIn = 1'b1;
    repeat (40) @(negedge clk);
    #1 check(pwrDown == 1'b0, "R1", pwrDown, 0);

    // R4: polarity high, count to threshold and saturate
    runIdle(1'b1, "R4");
    repeat (20) @(negedge clk);
    #1 check(pwrDown == 1'b1, "R4", pwrDown, 1);

    // R2: a single edge clears the flag
    strobeIn = ~strobeIn;
    @(negedge clk);
    #1 check(pwrDown == 1'b0, "R2", pwrDown, 0);

    // R2: pulsing strobe never powers down
    writeReg(1'b0, 8'h03);
    for (int k = 0; k < 40; k++) begin
      strobeIn = ~strobeIn;
      @(negedge clk);
      #1 check(pwrDown == 1'b0, "R2", pwrDown, 0);
    end

    // R3: polarity low counts while strobe is held low
    runIdle(1'b0, "R3");

    // R3: strobe held at the unselected level never counts
    writeReg(1'b0, 8'h03);
    strobeIn = 1'b0;
    repeat (40) @(negedge clk);
    #1 check(pwrDown == 1'b0, "R3", pwrDown, 0);

    // R9: clearing enable drops the flag with the write
    runIdle(1'b1, "R9");
    writeReg(1'b0, 8'h00);
    #1 check(pwrDown == 1'b0, "R9", pwrDown, 0);

    // R5: chip select does not disturb the idle flag or gating
    runIdle(1'b1, "R5");
    chipSelN = 1'b1;
    #1 check(memEnable == 1'b0 && pwrDown == 1'b1, "R5", {memEnable, pwrDown}, 1);

    // R8: reset mid-run clears flag and registers
    writeReg(1'b1, 8'h7C);
    ctlIn = 3'b111;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    check(pwrDown == 1'b0, "R8", pwrDown, 0);
    check(ctlGated == 3'b111, "R8", ctlGated, 7);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule